// File: doc/BRIEF.md
# Video Frame DRAM Address Generator

This block turns one block-level video access request into a stream of external memory addresses, each made of a memory select, a bank, a row and a column. A decoder stage hands it the top-left corner of a luma or chroma block, a quarter-pel motion vector, the block size and a few flags. The block works out the rectangle of reference pixels that the stage needs, including the margin that sub-pel interpolation requires. It clamps that rectangle to the picture and walks it in raster order. Every two-pixel column group it visits becomes one address on a valid/ready output port.

The address map is built around 64-pixel-wide tiles. A luma tile is 64 lines tall and a chroma tile (interleaved Cb/Cr, half height) is 32 lines tall. Each tile lives in a single DRAM row. The low bits of the tile column and tile row choose the bank, so two neighbouring tiles never share a bank and moving into the next tile costs a bank switch rather than a row miss. With one or two memories, a chroma tile sits in the same DRAM row directly after its luma tile, so a chroma fetch that follows a luma fetch opens no new row. With four memories, luma and chroma go to separate memory pairs so that both can be fetched at once. Whenever a pair of memories holds a plane, the memory select flips every two pixels.

Slice-level settings (picture width, picture height, two reference order counts and the memory-count code) are loaded through a small write port. A request whose order count matches neither reference raises a one-cycle error and produces no addresses.

Top module: `vid_dram_addr_gen`

## Requirements
- R1: While reset is held and after its release, addr_valid and err are 0 and req_ready is 1.
- R2: With both motion vector fractions zero, the window is S×S at (x+mvx/4, y+mvy/4), where S is 4 (req_size=0) or 8 (req_size=1). If either fraction is non-zero, the window is (S+5)×(S+5) and starts 2 pixels left of and above that point. The number of addresses is rows × ceil(cols/2).
- R3: Window sample x is clamped to 0..width-1 and window sample y is clamped to 0..lines-1, where lines is the plane height (luma: height; chroma: height/2; halved again in field mode). The emitted address is that of the clamped pixel.
- R4: A request whose POC equals neither cfg register 2 (reference 0, checked first) nor register 3 (reference 1) is accepted, pulses err for exactly one cycle and emits no address.
- R5: Addresses come row by row, and within a row at x = x0, x0+2, …. addr_last is 1 only on the final address. The cycle after the final handshake, addr_valid is 0 and req_ready is 1.
- R6: While addr_valid is high and addr_ready is low, all address outputs hold their value.
- R7: addr_bank = {ty[0], tx[0]}, where tx = x/64 and ty = line/64 (luma) or line/32 (chroma).
- R8: addr_row = ref·1024 + (ty/2)·ceil(width/128) + tx/2, with ref 0 or 1 as chosen in R4.
- R9: For memory code 0 (one memory), mem is 0 and the offset is ly·32 + lx/2. For code 1 (two memories), mem is x[1] and the offset is ly·16 + lx/4. Here lx = x mod 64 and ly is the line within the tile. Luma col = offset; chroma col = offset + 2048 (code 0) or + 1024 (code 1).
- R10: For memory code 2 or 3 (four memories), mem = {chroma, x[1]} and col = ly·16 + lx/4 for both planes.
- R11: With req_field set, window line n of the field maps to picture line 2n + req_bottom.
- R12: addr_write equals the req_write of the request being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Slice register write strobe |
| cfg_addr | input | 3 | 0 width, 1 height, 2 POC ref0, 3 POC ref1, 4 memory code |
| cfg_wdata | input | 12 | Slice register write data |
| req_valid | input | 1 | Block request valid |
| req_ready | output | 1 | Block request accepted when high (idle) |
| req_x | input | 12 | Block origin x in plane pixels |
| req_y | input | 12 | Block origin y in plane lines (field lines in field mode) |
| req_mvx | input | 14 | Signed horizontal motion vector, quarter pel |
| req_mvy | input | 14 | Signed vertical motion vector, quarter pel |
| req_size | input | 1 | 0: 4×4 block, 1: 8×8 block |
| req_chroma | input | 1 | 1: chroma plane |
| req_field | input | 1 | 1: field access |
| req_bottom | input | 1 | Field parity when req_field is 1 |
| req_write | input | 1 | Access direction carried to the output |
| req_poc | input | 8 | Picture order count of the reference |
| addr_valid | output | 1 | Address valid |
| addr_ready | input | 1 | Address consumer ready |
| addr_mem | output | 2 | Memory select |
| addr_bank | output | 2 | Bank |
| addr_row | output | 13 | DRAM row |
| addr_col | output | 12 | Column in two-pixel units |
| addr_last | output | 1 | Final address of the request |
| addr_write | output | 1 | Access direction |
| err | output | 1 | One-cycle pulse on unknown reference |

## Verification
Directed requests pin down the interesting cases. A whole-pixel 4×4 and a quarter-pel 8×8 show the narrow and widened windows apart, and a 13×13 window placed across a tile corner makes the bank and row terms both change within one burst. Vectors that point far outside the top-left and bottom-right corners separate clamping from wrap-around. Each memory code is exercised with both luma and chroma, which tells interleaved placement from split placement, and field requests of both parities are included. Random requests over reconfigured picture sizes, together with random consumer stalls, then cover the mix of window, clamp and mapping paths with back-pressure at every position in a burst.

// File: rtl/vfa_pkg.sv
// Package: shared widths and the latched window descriptor for the
// video frame DRAM address generator.
// Assumes pictures no larger than 4095x4095 and vectors within +/-2048 pixels.
package vfa_pkg;
    localparam int CW   = 12;      // coordinate / dimension width
    localparam int SCW  = CW + 2;  // signed working width for window origins
    localparam int MVW  = 14;      // quarter-pel motion vector width
    localparam int POCW = 8;       // picture order count width
    localparam int WW   = 4;       // window dimension width (max 13)

    // Fetch window after motion vector application, before clamping.
    typedef struct packed {
        logic signed [SCW-1:0] x0;
        logic signed [SCW-1:0] y0;
        logic [WW-1:0]         dim;
        logic                  frame;
        logic                  chroma;
        logic                  field;
        logic                  bottom;
        logic                  write;
    } win_t;
endpackage

// File: rtl/vfa_slice_regs.sv
// Module: slice-level settings written through a simple strobe port.
// Assumes software keeps them stable while a request is being streamed.
module vfa_slice_regs
    import vfa_pkg::*;
#(
    parameter int RST_WIDTH  = 64,
    parameter int RST_HEIGHT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [CW-1:0]   cfg_wdata,
    output logic [CW-1:0]   pic_width,
    output logic [CW-1:0]   pic_height,
    output logic [POCW-1:0] poc_ref0,
    output logic [POCW-1:0] poc_ref1,
    output logic [1:0]      mem_code
);
    // Register writes; unknown addresses are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pic_width  <= CW'(RST_WIDTH);
            pic_height <= CW'(RST_HEIGHT);
            poc_ref0   <= '0;
            poc_ref1   <= POCW'(1);
            mem_code   <= 2'd0;
        end else if (cfg_we) begin
            case (cfg_addr)
                3'd0:    pic_width  <= cfg_wdata;
                3'd1:    pic_height <= cfg_wdata;
                3'd2:    poc_ref0   <= cfg_wdata[POCW-1:0];
                3'd3:    poc_ref1   <= cfg_wdata[POCW-1:0];
                3'd4:    mem_code   <= cfg_wdata[1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vfa_window.sv
// Module: derives the fetch window from a block request.
// The quarter-pel vector's integer part moves the origin; any fractional
// part widens the window by 5 and moves its origin 2 pixels up and left.
// Also resolves the reference picture from the two registered order counts.
module vfa_window
    import vfa_pkg::*;
(
    input  logic                   req_size,
    input  logic [CW-1:0]          req_x,
    input  logic [CW-1:0]          req_y,
    input  logic signed [MVW-1:0]  req_mvx,
    input  logic signed [MVW-1:0]  req_mvy,
    input  logic                   req_chroma,
    input  logic                   req_field,
    input  logic                   req_bottom,
    input  logic                   req_write,
    input  logic [POCW-1:0]        req_poc,
    input  logic [POCW-1:0]        poc_ref0,
    input  logic [POCW-1:0]        poc_ref1,
    output win_t                   win,
    output logic                   ref_hit
);
    logic signed [SCW-1:0] mvx_int, mvy_int, margin;
    logic [WW-1:0]         base_dim;
    logic                  has_frac;

    // Window origin, size and reference selection.
    always_comb begin
        mvx_int    = SCW'(req_mvx >>> 2);
        mvy_int    = SCW'(req_mvy >>> 2);
        has_frac   = (req_mvx[1:0] != 2'd0) || (req_mvy[1:0] != 2'd0);
        base_dim   = req_size ? WW'(8) : WW'(4);
        margin     = has_frac ? SCW'(2) : SCW'(0);
        win.x0     = $signed({2'b00, req_x}) + mvx_int - margin;
        win.y0     = $signed({2'b00, req_y}) + mvy_int - margin;
        win.dim    = has_frac ? base_dim + WW'(5) : base_dim;
        win.frame  = (req_poc != poc_ref0);
        win.chroma = req_chroma;
        win.field  = req_field;
        win.bottom = req_bottom;
        win.write  = req_write;
        ref_hit    = (req_poc == poc_ref0) || (req_poc == poc_ref1);
    end
endmodule

// File: rtl/vfa_streamer.sv
// Module: walks a latched window in raster order, one sample per two-pixel
// column group, and clamps each sample to the plane. Valid/ready output;
// a new request is taken only while idle. Unknown reference: one-cycle err.
module vfa_streamer
    import vfa_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  win_t          win_in,
    input  logic          ref_hit,
    input  logic [CW-1:0] pic_width,
    input  logic [CW-1:0] pic_height,
    output logic          addr_valid,
    input  logic          addr_ready,
    output logic          addr_last,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_line,
    output logic          s_frame,
    output logic          s_chroma,
    output logic          s_write,
    output logic          err
);
    win_t          win_q;
    logic          busy_q, err_q;
    logic [WW-1:0] row_q, grp_q, groups;
    logic          accept, row_end;
    logic [CW-1:0] xlim, ylim, lines_f, lines;
    logic signed [SCW-1:0] xs, ys;
    logic [CW-1:0] py;

    function automatic logic [CW-1:0] clampc(input logic signed [SCW-1:0] v,
                                             input logic [CW-1:0] hi);
        if (v < 0)                          return '0;
        else if (v > $signed({2'b00, hi})) return hi;
        else                                return v[CW-1:0];
    endfunction

    // Handshake and end-of-window decode.
    always_comb begin
        accept    = req_valid && !busy_q;
        groups    = (win_q.dim + WW'(1)) >> 1;
        row_end   = (grp_q == groups - WW'(1));
        addr_last = row_end && (row_q == win_q.dim - WW'(1));
    end

    // Request latch, raster counters and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            win_q  <= '0;
            row_q  <= '0;
            grp_q  <= '0;
        end else begin
            err_q <= accept && !ref_hit;
            if (accept && ref_hit) begin
                busy_q <= 1'b1;
                win_q  <= win_in;
                row_q  <= '0;
                grp_q  <= '0;
            end else if (busy_q && addr_ready) begin
                if (addr_last) begin
                    busy_q <= 1'b0;
                end else if (row_end) begin
                    grp_q <= '0;
                    row_q <= row_q + WW'(1);
                end else begin
                    grp_q <= grp_q + WW'(1);
                end
            end
        end
    end

    // Sample position, plane limits and clamping.
    always_comb begin
        xs       = win_q.x0 + $signed({{(SCW-WW-1){1'b0}}, grp_q, 1'b0});
        ys       = win_q.y0 + $signed({{(SCW-WW){1'b0}}, row_q});
        lines_f  = win_q.field  ? (pic_height >> 1) : pic_height;
        lines    = win_q.chroma ? (lines_f >> 1)    : lines_f;
        xlim     = pic_width - CW'(1);
        ylim     = lines - CW'(1);
        pix_x    = clampc(xs, xlim);
        py       = clampc(ys, ylim);
        pix_line = win_q.field ? {py[CW-2:0], win_q.bottom} : py;
    end

    assign req_ready  = !busy_q;
    assign addr_valid = busy_q;
    assign err        = err_q;
    assign s_frame    = win_q.frame;
    assign s_chroma   = win_q.chroma;
    assign s_write    = win_q.write;

    // R6: a stalled address must not move.
    assert_hold_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(pix_x)
                                         && $stable(pix_line) && $stable(addr_last)));

    // R5: the final handshake returns the block to idle.
    assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_ready && addr_last) |=> (!addr_valid && req_ready));

    // R4: an error pulse never comes with addresses and lasts one cycle.
    assert_err_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!addr_valid && req_ready));
    assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !req_valid) |=> !err);
endmodule

// File: rtl/vfa_map.sv
// Module: maps one clamped pixel to memory, bank, row and column.
// Tiles are 64 pixels wide; 64 lines for luma, 32 for chroma. Bank is the
// low bit of tile row and column. One/two memories: chroma shares the luma
// tile's row after the luma part. Four memories: chroma on its own pair.
module vfa_map
    import vfa_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 12,
    parameter int FRAME_ROWS = 1024
) (
    input  logic [CW-2:0]    px_pair,   // pixel x with bit 0 dropped
    input  logic [CW-1:0]    pline,
    input  logic             chroma,
    input  logic             frame,
    input  logic [1:0]       mem_code,
    input  logic [CW-1:0]    pic_width,
    output logic [1:0]       mem_sel,
    output logic [1:0]       bank,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col
);
    localparam int GPL_ONE   = 32;              // groups per tile line, one memory
    localparam int GPL_PAIR  = 16;              // groups per tile line, memory pair
    localparam int LUMA_ONE  = 64 * GPL_ONE;    // luma part of a row, one memory
    localparam int LUMA_PAIR = 64 * GPL_PAIR;   // luma part of a row, memory pair

    logic                pair, four, lane;
    logic [CW-7:0]       tx;
    logic [CW-6:0]       ty;
    logic [5:0]          ly;
    logic [10:0]         offs;
    logic [CW:0]         tiles_per_row;
    logic [ROW_W-1:0]    frame_base;
    logic [COL_W-1:0]    chroma_base;

    // Tile coordinates, in-tile offset, row and column.
    always_comb begin
        pair          = (mem_code != 2'd0);
        four          = mem_code[1];
        lane          = pair && px_pair[0];
        tx            = px_pair[CW-2:5];
        ty            = chroma ? pline[CW-1:5] : {1'b0, pline[CW-1:6]};
        ly            = chroma ? {1'b0, pline[4:0]} : pline[5:0];
        offs          = pair ? {1'b0, ly, px_pair[4:1]} : {ly, px_pair[4:0]};
        chroma_base   = (!four && chroma) ? (pair ? COL_W'(LUMA_PAIR) : COL_W'(LUMA_ONE))
                                          : '0;
        col           = COL_W'(offs) + chroma_base;
        mem_sel       = four ? {chroma, lane} : {1'b0, lane};
        bank          = {ty[0], tx[0]};
        tiles_per_row = ({1'b0, pic_width} + (CW+1)'(127)) >> 7;
        frame_base    = frame ? ROW_W'(FRAME_ROWS) : '0;
        row           = frame_base + ROW_W'(ty >> 1) * ROW_W'(tiles_per_row)
                        + ROW_W'(tx >> 1);
    end
endmodule

// File: rtl/vid_dram_addr_gen.sv
// Module: top of the video frame DRAM address generator. Slice registers,
// window derivation, raster streaming and the pixel-to-DRAM map.
// Assumes slice registers are written only while no request is in flight.
module vid_dram_addr_gen
    import vfa_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int COL_W      = 12,
    parameter int FRAME_ROWS = 1024,
    parameter int RST_WIDTH  = 64,
    parameter int RST_HEIGHT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [CW-1:0]         cfg_wdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CW-1:0]         req_x,
    input  logic [CW-1:0]         req_y,
    input  logic signed [MVW-1:0] req_mvx,
    input  logic signed [MVW-1:0] req_mvy,
    input  logic                  req_size,
    input  logic                  req_chroma,
    input  logic                  req_field,
    input  logic                  req_bottom,
    input  logic                  req_write,
    input  logic [POCW-1:0]       req_poc,
    output logic                  addr_valid,
    input  logic                  addr_ready,
    output logic [1:0]            addr_mem,
    output logic [1:0]            addr_bank,
    output logic [ROW_W-1:0]      addr_row,
    output logic [COL_W-1:0]      addr_col,
    output logic                  addr_last,
    output logic                  addr_write,
    output logic                  err
);
    logic [CW-1:0]   pic_width, pic_height, pix_x, pix_line;
    logic [POCW-1:0] poc_ref0, poc_ref1;
    logic [1:0]      mem_code;
    win_t            win;
    logic            ref_hit, s_frame, s_chroma;

    vfa_slice_regs #(.RST_WIDTH(RST_WIDTH), .RST_HEIGHT(RST_HEIGHT)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pic_width(pic_width), .pic_height(pic_height),
        .poc_ref0(poc_ref0), .poc_ref1(poc_ref1), .mem_code(mem_code));

    vfa_window u_win (
        .req_size(req_size), .req_x(req_x), .req_y(req_y),
        .req_mvx(req_mvx), .req_mvy(req_mvy), .req_chroma(req_chroma),
        .req_field(req_field), .req_bottom(req_bottom), .req_write(req_write),
        .req_poc(req_poc), .poc_ref0(poc_ref0), .poc_ref1(poc_ref1),
        .win(win), .ref_hit(ref_hit));

    vfa_streamer u_stream (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .win_in(win), .ref_hit(ref_hit), .pic_width(pic_width),
        .pic_height(pic_height), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr_last(addr_last), .pix_x(pix_x), .pix_line(pix_line),
        .s_frame(s_frame), .s_chroma(s_chroma), .s_write(addr_write), .err(err));

    vfa_map #(.ROW_W(ROW_W), .COL_W(COL_W), .FRAME_ROWS(FRAME_ROWS)) u_map (
        .px_pair(pix_x[CW-1:1]), .pline(pix_line), .chroma(s_chroma),
        .frame(s_frame), .mem_code(mem_code), .pic_width(pic_width),
        .mem_sel(addr_mem), .bank(addr_bank), .row(addr_row), .col(addr_col));

    // R3: every streamed sample lies inside the picture width.
    assert_x_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (pix_x < pic_width));

    // R9: a single memory is always memory 0.
    assert_one_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && mem_code == 2'd0) |-> (addr_mem == 2'd0));

    // R10: four memories split planes by pair and keep columns in the low half.
    assert_four_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && mem_code[1]) |-> (addr_mem[1] == s_chroma
                                         && addr_col < COL_W'(1024)));
endmodule

// File: tb/test_vid_dram_addr_gen.sv
module test_vid_dram_addr_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic req_valid = 1'b0, req_size = 1'b0, req_chroma = 1'b0;
    logic req_field = 1'b0, req_bottom = 1'b0, req_write = 1'b0;
    logic [11:0] req_x = '0, req_y = '0;
    logic signed [13:0] req_mvx = '0, req_mvy = '0;
    logic [7:0] req_poc = '0;
    logic addr_ready = 1'b0;
    logic req_ready, addr_valid, addr_last, addr_write, err;
    logic [1:0] addr_mem, addr_bank;
    logic [12:0] addr_row;
    logic [11:0] addr_col;

    int n_checks = 0, n_fail = 0;
    int cur_w = 64, cur_h = 64, cur_mode = 0, poc0 = 0, poc1 = 1;

    always #10 clk = ~clk;

    vid_dram_addr_gen i_vid_dram_addr_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_mvx(req_mvx), .req_mvy(req_mvy),
        .req_size(req_size), .req_chroma(req_chroma), .req_field(req_field),
        .req_bottom(req_bottom), .req_write(req_write), .req_poc(req_poc),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_mem(addr_mem),
        .addr_bank(addr_bank), .addr_row(addr_row), .addr_col(addr_col),
        .addr_last(addr_last), .addr_write(addr_write), .err(err));

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, expv);
        end
    endtask

    function automatic int clampi(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // Expected address of window sample (g, r): {mem, bank, row, col}.
    function automatic logic [28:0] exp_addr(input int x0, input int y0, input int g,
            input int r, input int ch, input int fld, input int bot, input int frm);
        int lines, px, py, pl, tx, ty, lx, ly, offs, col, mem, bank, row;
        bit pair, four;
        lines = fld ? cur_h / 2 : cur_h;
        if (ch) lines = lines / 2;
        px   = clampi(x0 + 2 * g, cur_w - 1);
        py   = clampi(y0 + r, lines - 1);
        pl   = fld ? 2 * py + bot : py;
        pair = (cur_mode != 0);
        four = (cur_mode >= 2);
        tx   = px / 64;
        ty   = ch ? pl / 32 : pl / 64;
        lx   = px % 64;
        ly   = ch ? pl % 32 : pl % 64;
        offs = pair ? ly * 16 + lx / 4 : ly * 32 + lx / 2;
        col  = offs + ((!four && ch) ? (pair ? 1024 : 2048) : 0);
        mem  = (four ? ch * 2 : 0) + (pair ? (px / 2) % 2 : 0);
        bank = (ty % 2) * 2 + (tx % 2);
        row  = frm * 1024 + (ty / 2) * ((cur_w + 127) / 128) + tx / 2;
        return {2'(mem), 2'(bank), 13'(row), 12'(col)};
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: cur_w = d;
            1: cur_h = d;
            2: poc0 = d;
            3: poc1 = d;
            4: cur_mode = d;
            default: ;
        endcase
    endtask

    task automatic do_req(input int x, input int y, input int mvx, input int mvy,
                          input int sz, input int ch, input int fld, input int bot,
                          input int wr, input int poc, input int stall_pct,
                          input string tag);
        int s, dim, marg, x0, y0, groups, total, idx, cyc, frm;
        bit frac, hit, stalled;
        logic [30:0] held;
        logic [28:0] e;
        string maptag;
        s     = sz ? 8 : 4;
        frac  = (mvx % 4 != 0) || (mvy % 4 != 0);
        dim   = frac ? s + 5 : s;
        marg  = frac ? 2 : 0;
        x0    = x + (mvx >>> 2) - marg;
        y0    = y + (mvy >>> 2) - marg;
        groups = (dim + 1) / 2;
        total = dim * groups;
        hit   = (poc == poc0) || (poc == poc1);
        frm   = (poc == poc0) ? 0 : 1;
        maptag = fld ? "R11" : (cur_mode >= 2 ? "R10" : "R9");
        @(negedge clk);
        chk(req_ready == 1'b1, "R5", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_x = 12'(x); req_y = 12'(y);
        req_mvx = 14'(mvx); req_mvy = 14'(mvy); req_size = sz[0];
        req_chroma = ch[0]; req_field = fld[0]; req_bottom = bot[0];
        req_write = wr[0]; req_poc = 8'(poc);
        @(negedge clk);
        req_valid = 1'b0;
        if (!hit) begin
            chk(err == 1'b1 && addr_valid == 1'b0, "R4", "err pulse", int'(err), 1);
            @(negedge clk);
            chk(err == 1'b0 && addr_valid == 1'b0 && req_ready == 1'b1,
                "R4", "err single, no address", int'(err) + 2 * int'(addr_valid), 0);
            return;
        end
        idx = 0; cyc = 0; stalled = 1'b0; held = '0;
        while (idx < total) begin
            if (cyc > 2000) begin
                chk(1'b0, tag, "burst timeout, addresses seen", idx, total);
                addr_ready = 1'b0;
                return;
            end
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (!addr_valid) begin
                chk(1'b0, tag, "addr_valid dropped early, index", idx, total);
                addr_ready = 1'b0;
                return;
            end
            if (stalled)
                chk({addr_mem, addr_bank, addr_row, addr_col, addr_last, addr_write} == held,
                    "R6", "stalled address changed", int'(addr_col), int'(held[13:2]));
            held = {addr_mem, addr_bank, addr_row, addr_col, addr_last, addr_write};
            if (($urandom % 100) < stall_pct) begin
                addr_ready = 1'b0;
                stalled = 1'b1;
            end else begin
                addr_ready = 1'b1;
                stalled = 1'b0;
                e = exp_addr(x0, y0, idx % groups, idx / groups, ch, fld, bot, frm);
                chk(addr_bank == e[26:25], "R7", "bank", int'(addr_bank), int'(e[26:25]));
                chk(addr_row == e[24:12], "R8", "row", int'(addr_row), int'(e[24:12]));
                chk(addr_mem == e[28:27], maptag, "mem", int'(addr_mem), int'(e[28:27]));
                chk(addr_col == e[11:0], maptag, "col", int'(addr_col), int'(e[11:0]));
                chk(addr_write == wr[0], "R12", "write flag", int'(addr_write), wr);
                chk(addr_last == (idx == total - 1), "R5", "last flag",
                    int'(addr_last), int'(idx == total - 1));
                idx++;
            end
        end
        @(negedge clk);
        addr_ready = 1'b0;
        chk(addr_valid == 1'b0 && req_ready == 1'b1, tag, "idle after burst of",
            int'(addr_valid), 0);
        chk(idx == total, "R2", "address count", idx, total);
    endtask

    // Global watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(addr_valid == 1'b0, "R1", "addr_valid in reset", int'(addr_valid), 0);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
        chk(err == 1'b0, "R1", "err in reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid == 1'b0 && req_ready == 1'b1 && err == 1'b0, "R1",
            "state after release", int'(addr_valid), 0);

        cfg_write(0, 256); cfg_write(1, 128); cfg_write(2, 10); cfg_write(3, 20);
        cfg_write(4, 0);
        // R2: whole-pixel 4x4 and quarter-pel 8x8 windows
        do_req(64, 0, 8, 4, 0, 0, 0, 0, 0, 10, 0, "R2");
        do_req(60, 60, 1, 0, 1, 0, 0, 0, 1, 20, 30, "R2");
        // R7/R8: 13x13 window across a tile corner, second reference
        do_req(120, 58, 2, 2, 1, 0, 0, 0, 0, 20, 0, "R8");
        // R3: far outside top-left and bottom-right
        do_req(0, 0, -400, -400, 1, 0, 0, 0, 0, 10, 20, "R3");
        do_req(250, 124, 600, 600, 1, 0, 0, 0, 0, 10, 20, "R3");
        do_req(10, 60, 3, 0, 1, 1, 0, 0, 0, 10, 0, "R3");
        // R4: unknown reference
        do_req(16, 16, 0, 0, 1, 0, 0, 0, 0, 77, 0, "R4");
        // R9: one memory chroma, two memories luma and chroma
        do_req(32, 40, 0, 0, 1, 1, 0, 0, 0, 10, 0, "R9");
        cfg_write(4, 1);
        do_req(62, 8, 0, 0, 1, 0, 0, 0, 0, 10, 40, "R9");
        do_req(62, 8, 2, 0, 1, 1, 0, 0, 1, 20, 0, "R9");
        // R10: four memories, codes 2 and 3
        cfg_write(4, 2);
        do_req(100, 30, 0, 0, 1, 0, 0, 0, 0, 10, 0, "R10");
        do_req(100, 30, 0, 0, 1, 1, 0, 0, 0, 10, 0, "R10");
        cfg_write(4, 3);
        do_req(4, 20, -3, 5, 0, 1, 0, 0, 1, 20, 50, "R10");
        // R11: field top and bottom
        cfg_write(4, 0);
        do_req(8, 30, 0, 0, 1, 0, 1, 0, 0, 10, 0, "R11");
        do_req(8, 30, 1, 1, 1, 0, 1, 1, 0, 10, 0, "R11");
        do_req(8, 14, 0, 0, 1, 1, 1, 1, 0, 10, 0, "R11");

        // Random requests over several configurations.
        for (int k = 0; k < 80; k++) begin
            int wsel, px, py, pc;
            if (k % 10 == 0) begin
                wsel = 64 + 16 * int'($urandom_range(0, 36));
                cfg_write(0, wsel);
                cfg_write(1, 64 + 16 * int'($urandom_range(0, 28)));
                cfg_write(4, int'($urandom_range(0, 3)));
            end
            px = int'($urandom_range(0, cur_w - 1));
            py = int'($urandom_range(0, cur_h / 4 - 1));
            pc = int'($urandom_range(0, 9));
            do_req(px, py, int'($urandom_range(0, 200)) - 100,
                   int'($urandom_range(0, 200)) - 100, int'($urandom_range(0, 1)),
                   int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                   int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                   (pc == 0) ? 55 : ((pc < 5) ? poc0 : poc1), 35, "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule